// File: doc/BRIEF.md
# Serial Command Bus Master

This block lets a host on an asynchronous serial line reach any address of a 32-bit system bus. The host sends a command byte, then a 32-bit start address, and for writes the data words. The block turns each word into one single-beat transfer on the bus, where it acts as a master. Read words are sent back to the host over the serial line.

The serial line runs at a fixed rate set by a clock divider parameter. The divider produces a tick at 16 times the bit rate. The receiver uses this tick to find the middle of each bit, and the transmitter uses it to time each bit. Bus ownership is handled with a request and a grant. The block raises its request, keeps the transfer fields steady, and treats a transfer as done in the first cycle where the grant and the slave's ready are both high.

Top module: `dbglink_master`

## Requirements
- R1: Both serial directions use 8N1 framing: one low start bit, eight data bits with the LSB first, and one high stop bit. The line rests high when idle.
- R2: One bit lasts 16 ticks, and a tick comes every TICK_DIV clocks. The receiver takes each data bit near its middle.
- R3: In the command byte, bit 7 high selects write and bit 7 low selects read. Bits 5:0 hold the word count minus one, so one command moves 1 to 64 words. Bit 6 has no effect.
- R4: The four address bytes follow the command byte, most significant byte first.
- R5: For a write, each data word arrives as four bytes, most significant byte first, and becomes one write transfer. A write command sends no bytes back on ser_tx.
- R6: Word k of a command uses the start address plus 4*k. The address wraps modulo 2^32.
- R7: bus_req rises only after the whole address has arrived, and for a write only after the whole data word has arrived. From then until a cycle with bus_gnt and bus_rdy both high, bus_req, bus_addr, bus_we and bus_wdata hold steady.
- R8: Each read word is sent back as four bytes, most significant byte first. The next word of the same command is fetched only after those four bytes have been handed to the transmitter.
- R9: If ser_rx goes low for less than half a bit, the receiver discards it and no byte is received.
- R10: After reset, bus_req is low, ser_tx is high, and the block waits for a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_rx | input | 1 | Serial data from the host |
| ser_tx | output | 1 | Serial data to the host |
| bus_req | output | 1 | Bus request, held high for a pending transfer |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_addr | output | 32 | Transfer address |
| bus_we | output | 1 | High for a write transfer |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data from the slave |
| bus_rdy | input | 1 | Slave ready; completes the transfer while granted |

## Verification
The bench varies grant and ready latency, and it flags any transfer field that moves while the request is still pending. A design that let the address or data slip during a wait would be caught here. Multi-word commands that cross the top of the address space are used to expose a wrong word step or a missing wrap. Command bytes with bit 6 set are used to expose decoding that treats bit 6 as part of the count. A 64-word write probes the widest count, which would show a count field that is one bit too narrow or off by one. A short low glitch is sent before a real command; a receiver that did not check the start bit again would shift every later byte. Write commands are watched for any stray response bytes.

// File: rtl/dbglink_pkg.sv
package dbglink_pkg;
  localparam int unsigned OVS        = 16;
  localparam int unsigned START_MID  = OVS / 2 - 1;
  localparam int unsigned CNT_W      = 6;
  localparam int unsigned WR_BIT     = 7;
  localparam int unsigned ADDR_STEP  = 4;

  typedef enum logic [2:0] {
    E_CTRL, E_ADDR, E_WDATA, E_BUS, E_RESP
  } eng_state_t;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_t;
endpackage

// File: rtl/dbglink_baud.sv
module dbglink_baud #(
  parameter int unsigned DIV = 27
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_d;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end

  generate
    if (DIV > 1) begin : g_gap
      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dbglink_rx.sv
module dbglink_rx
  import dbglink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       valid,
  output logic [7:0] data
);
  localparam logic [3:0] T_LAST = 4'(OVS - 1);
  localparam logic [3:0] T_MID  = 4'(START_MID);

  logic       s1_q, s2_q;
  rx_state_t  st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       valid_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    if (tick) begin
      case (st_q)
        RX_IDLE: if (!s2_q) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
        RX_START: if (cnt_q == T_MID) begin
          cnt_d = '0;
          bit_d = '0;
          st_d  = s2_q ? RX_IDLE : RX_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        RX_DATA: if (cnt_q == T_LAST) begin
          cnt_d = '0;
          sh_d  = {s2_q, sh_q[7:1]};
          bit_d = bit_q + 1'b1;
          if (bit_q == 3'd7) st_d = RX_STOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        RX_STOP: if (cnt_q == T_LAST) begin
          valid_d = s2_q;
          st_d    = RX_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      valid <= 1'b0;
    end else begin
      s1_q  <= rxd;
      s2_q  <= s1_q;
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      valid <= valid_d;
    end
  end

  assign data = sh_q;

  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

// File: rtl/dbglink_tx.sv
module dbglink_tx
  import dbglink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] data,
  output logic       ready,
  output logic       txd
);
  localparam logic [3:0] T_LAST = 4'(OVS - 1);

  logic       act_q, act_d;
  logic [8:0] sh_q, sh_d;
  logic [3:0] bit_q, bit_d;
  logic [3:0] cnt_q, cnt_d;
  logic       txd_d;

  always_comb begin
    act_d = act_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    cnt_d = cnt_q;
    txd_d = txd;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        sh_d  = {1'b1, data};
        bit_d = '0;
        cnt_d = '0;
        txd_d = 1'b0;
      end
    end else if (tick) begin
      if (cnt_q == T_LAST) begin
        cnt_d = '0;
        if (bit_q == 4'd9) begin
          act_d = 1'b0;
          txd_d = 1'b1;
        end else begin
          txd_d = sh_q[0];
          sh_d  = {1'b1, sh_q[8:1]};
          bit_d = bit_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sh_q  <= '1;
      bit_q <= '0;
      cnt_q <= '0;
      txd   <= 1'b1;
    end else begin
      act_q <= act_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
      cnt_q <= cnt_d;
      txd   <= txd_d;
    end
  end

  assign ready = !act_q;

  // R1
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> txd);
endmodule

// File: rtl/dbglink_engine.sv
module dbglink_engine
  import dbglink_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_ready,
  output logic              tx_start,
  output logic [7:0]        tx_byte,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [DATA_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy
);
  localparam int unsigned NBYTES = DATA_W / 8;
  localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(ADDR_STEP);

  eng_state_t        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              wr_q, wr_d;
  logic              last_q, last_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [DATA_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              done;

  assign done = bus_gnt && bus_rdy;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    wr_d     = wr_q;
    last_d   = last_q;
    left_d   = left_q;
    addr_d   = addr_q;
    data_d   = data_q;
    tx_start = 1'b0;
    case (st_q)
      E_CTRL: if (rx_valid) begin
        wr_d   = rx_byte[WR_BIT];
        left_d = rx_byte[CNT_W-1:0];
        idx_d  = '0;
        st_d   = E_ADDR;
      end
      E_ADDR: if (rx_valid) begin
        addr_d = {addr_q[DATA_W-9:0], rx_byte};
        idx_d  = idx_q + 1'b1;
        if (idx_q == IDX_LAST) begin
          idx_d = '0;
          st_d  = wr_q ? E_WDATA : E_BUS;
        end
      end
      E_WDATA: if (rx_valid) begin
        data_d = {data_q[DATA_W-9:0], rx_byte};
        idx_d  = idx_q + 1'b1;
        if (idx_q == IDX_LAST) begin
          idx_d = '0;
          st_d  = E_BUS;
        end
      end
      E_BUS: if (done) begin
        last_d = (left_q == '0);
        if (!wr_q) data_d = bus_rdata;
        if (left_q != '0) begin
          left_d = left_q - 1'b1;
          addr_d = addr_q + STEP;
        end
        idx_d = '0;
        if (wr_q) st_d = (left_q == '0) ? E_CTRL : E_WDATA;
        else      st_d = E_RESP;
      end
      E_RESP: if (tx_ready) begin
        tx_start = 1'b1;
        data_d   = {data_q[DATA_W-9:0], 8'h00};
        idx_d    = idx_q + 1'b1;
        if (idx_q == IDX_LAST) begin
          idx_d = '0;
          st_d  = last_q ? E_CTRL : E_BUS;
        end
      end
      default: st_d = E_CTRL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_CTRL;
      idx_q  <= '0;
      wr_q   <= 1'b0;
      last_q <= 1'b0;
      left_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      wr_q   <= wr_d;
      last_q <= last_d;
      left_q <= left_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign bus_req   = (st_q == E_BUS);
  assign bus_we    = wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = data_q;
  assign tx_byte   = data_q[DATA_W-1:DATA_W-8];

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !done) |=> (bus_req && $stable(bus_addr) &&
                            $stable(bus_wdata) && $stable(bus_we)));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && done && left_q != '0) |=> (bus_addr == $past(bus_addr) + STEP));

  // R5
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !wr_q);
endmodule

// File: rtl/dbglink_master.sv
module dbglink_master #(
  parameter int unsigned TICK_DIV = 27,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_rx,
  output logic              ser_tx,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [DATA_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy
);
  logic       rst_a_q, rst_b_q;
  logic       tick;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       tx_ready, tx_start;
  logic [7:0] tx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end

  dbglink_baud #(.DIV(TICK_DIV)) u_baud (
    .clk(clk), .rst_n(rst_b_q), .tick(tick)
  );

  dbglink_rx u_rx (
    .clk(clk), .rst_n(rst_b_q), .tick(tick), .rxd(ser_rx),
    .valid(rx_valid), .data(rx_byte)
  );

  dbglink_tx u_tx (
    .clk(clk), .rst_n(rst_b_q), .tick(tick), .start(tx_start),
    .data(tx_byte), .ready(tx_ready), .txd(ser_tx)
  );

  dbglink_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_b_q),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_ready(tx_ready), .tx_start(tx_start), .tx_byte(tx_byte),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy)
  );
endmodule

// File: tb/dbglink_master_bench.sv
module dbglink_master_bench;
  localparam int DIV  = 2;
  localparam int BITC = 16 * DIV;
  localparam int HALF = 8 * DIV;

  // {ctrl, start address, write seed}
  localparam logic [71:0] VEC [6] = '{
    {8'h00, 32'h1000_0000, 32'h0000_0000},
    {8'h80, 32'h2000_0004, 32'hDEAD_BEEF},
    {8'h02, 32'h0000_0100, 32'h0000_0000},
    {8'h83, 32'h8000_0010, 32'h1122_3344},
    {8'hC2, 32'hFFFF_FFF8, 32'hA0B0_C0D0},
    {8'h41, 32'hFFFF_FFFC, 32'h0000_0000}
  };

  logic        clk, rst_n, ser_rx, ser_tx;
  logic        bus_req, bus_gnt, bus_we, bus_rdy;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  int n_chk, n_fail, glat, rlat, pend;
  int log_cnt, rx_count, frame_err, stab_err;
  logic [31:0] log_addr [256];
  logic [31:0] log_data [256];
  logic        log_we   [256];
  logic [7:0]  rx_mem   [256];
  logic        prev_pend;
  logic [31:0] prev_addr, prev_wdata;
  logic        prev_we;
  logic [7:0]  mon_b;
  bit          done_flag;

  function automatic logic [31:0] rd_f(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  dbglink_master #(.TICK_DIV(DIV), .DATA_W(32)) u_dbglink_master (
    .clk(clk), .rst_n(rst_n), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign bus_gnt   = bus_req && (pend >= glat);
  assign bus_rdy   = bus_req && (pend >= glat + rlat);
  assign bus_rdata = rd_f(bus_addr);

  always @(posedge clk) begin
    if (bus_req && bus_gnt && bus_rdy) begin
      log_addr[log_cnt] <= bus_addr;
      log_data[log_cnt] <= bus_wdata;
      log_we[log_cnt]   <= bus_we;
      log_cnt <= log_cnt + 1;
      pend    <= 0;
    end else if (bus_req) pend <= pend + 1;
    else pend <= 0;
    if (prev_pend && (!bus_req || bus_addr !== prev_addr ||
        bus_wdata !== prev_wdata || bus_we !== prev_we))
      stab_err <= stab_err + 1;
    prev_pend  <= bus_req && !(bus_gnt && bus_rdy);
    prev_addr  <= bus_addr;
    prev_wdata <= bus_wdata;
    prev_we    <= bus_we;
  end

  always begin
    @(negedge ser_tx);
    repeat (HALF) @(negedge clk);
    if (ser_tx !== 1'b0) frame_err++;
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      mon_b[i] = ser_tx;
    end
    repeat (BITC) @(negedge clk);
    if (ser_tx !== 1'b1) frame_err++;
    rx_mem[rx_count[7:0]] = mon_b;
    rx_count++;
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    ser_rx = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rx = b[i];
      repeat (BITC) @(negedge clk);
    end
    ser_rx = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8]);
  endtask

  function automatic logic [31:0] resp_word(input int base);
    return {rx_mem[base[7:0]], rx_mem[8'(base+1)],
            rx_mem[8'(base+2)], rx_mem[8'(base+3)]};
  endfunction

  task automatic finish_run();
    chk(frame_err == 0, "R1 response framing errors", frame_err, 0);
    chk(stab_err == 0, "R7 fields moved while pending", stab_err, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; glat = 0; rlat = 0; pend = 0;
    log_cnt = 0; rx_count = 0; frame_err = 0; stab_err = 0;
    prev_pend = 1'b0; done_flag = 1'b0;
    ser_rx = 1'b1;
    rst_n  = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(bus_req == 1'b0, "R10 bus_req after reset", 32'(bus_req), 0);
    chk(ser_tx == 1'b1, "R10 ser_tx idle after reset", 32'(ser_tx), 1);

    for (int v = 0; v < 6; v++) begin
      logic [7:0]  ctrl;
      logic [31:0] a0, seed;
      int n, lb, rb;
      bit wr;
      ctrl = VEC[v][71:64];
      a0   = VEC[v][63:32];
      seed = VEC[v][31:0];
      wr   = ctrl[7];
      n    = int'(ctrl[5:0]) + 1;
      glat = v % 3;
      rlat = (v + 1) % 3;
      lb = log_cnt;
      rb = rx_count;
      send_byte(ctrl);
      send_word(a0);
      if (wr) begin
        for (int k = 0; k < n; k++) send_word(seed + 32'(k) * 32'h0101_0101);
        while (log_cnt < lb + n) @(negedge clk);
        repeat (20 * BITC) @(negedge clk);
        chk(rx_count == rb, "R5 write sent response bytes", rx_count - rb, 0);
      end else begin
        while (rx_count < rb + 4 * n) @(negedge clk);
        repeat (4 * BITC) @(negedge clk);
      end
      chk(log_cnt == lb + n, "R3 transfer count", log_cnt - lb, n);
      for (int k = 0; k < n; k++) begin
        logic [31:0] ea;
        ea = a0 + 32'(4 * k);
        chk(log_addr[lb + k] == ea, "R4 R6 transfer address", log_addr[lb + k], ea);
        chk(log_we[lb + k] == wr, "R3 direction", 32'(log_we[lb + k]), 32'(wr));
        if (wr)
          chk(log_data[lb + k] == seed + 32'(k) * 32'h0101_0101,
              "R5 write data", log_data[lb + k], seed + 32'(k) * 32'h0101_0101);
        else
          chk(resp_word(rb + 4 * k) == rd_f(ea), "R8 R2 read response",
              resp_word(rb + 4 * k), rd_f(ea));
      end
    end

    // R9: short low glitch, then a one-word read
    begin
      int lb, rb;
      lb = log_cnt;
      rb = rx_count;
      glat = 1; rlat = 1;
      ser_rx = 1'b0;
      repeat (3) @(negedge clk);
      ser_rx = 1'b1;
      repeat (3 * BITC) @(negedge clk);
      chk(log_cnt == lb, "R9 glitch caused transfer", log_cnt - lb, 0);
      send_byte(8'h00);
      send_word(32'h0000_0040);
      while (rx_count < rb + 4) @(negedge clk);
      chk(log_addr[lb] == 32'h0000_0040, "R9 address after glitch",
          log_addr[lb], 32'h0000_0040);
      chk(resp_word(rb) == rd_f(32'h0000_0040), "R9 data after glitch",
          resp_word(rb), rd_f(32'h0000_0040));
      repeat (4 * BITC) @(negedge clk);
    end

    // R3: widest count, 64 words
    begin
      int lb;
      lb = log_cnt;
      glat = 0; rlat = 0;
      send_byte(8'hBF);
      send_word(32'h0000_1000);
      for (int k = 0; k < 64; k++) send_word(32'(k) * 32'h0101_0101);
      while (log_cnt < lb + 64) @(negedge clk);
      repeat (4 * BITC) @(negedge clk);
      chk(log_cnt == lb + 64, "R3 64-word count", log_cnt - lb, 64);
      chk(log_addr[lb + 63] == 32'h0000_10FC, "R3 R6 last address",
          log_addr[lb + 63], 32'h0000_10FC);
      chk(log_data[lb + 63] == 32'd63 * 32'h0101_0101, "R3 R5 last data",
          log_data[lb + 63], 32'd63 * 32'h0101_0101);
      chk(bus_req == 1'b0, "R7 idle after command", 32'(bus_req), 0);
    end

    done_flag = 1'b1;
    finish_run();
  end
endmodule